// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block sits between two 16-bit buses, called A and B. It is split into two 8-bit channels that work on their own. In each channel, data can travel from A to B and from B to A, and each of those two paths has its own 8-bit storage element. Each path is steered by three active-low inputs:
- a path enable, which gates both storage and output drive;
- a hold strobe, which makes the storage transparent while it is low and freezes it when it returns high;
- a drive enable for the far port.

Tying the controls of the two channels together makes the block act as one 16-bit transceiver. Driving them separately gives two 8-bit transceivers.

The design uses a clock. A path is "open" while its path enable and its hold strobe are both low:
- While a path is open, the far port shows the near-port input in the same cycle (combinationally).
- While a path is open, the storage reloads from the near-port input at every rising clock edge.
- When the path closes, the storage keeps the value sampled at the last edge at which the path was open.

Neither port is a real inout pin. Each port is presented as a data vector plus a drive-enable vector, one bit per bus line, and the surrounding logic resolves the bus.

Top module: `bus_xcvr_latched`

## Requirements
- R1: A synchronous active-high reset clears every stored value to zero. While reset is held, or whenever the controls disable driving, all drive-enable bits are 0 and the output data bits are 0.
- R2: A path is open when its path enable (`*_pen_n`) is low and its hold strobe (`*_hold_n`) is low. While the path is open and its drive enable (`*_oen_n`) is low, the far-port output equals the current near-port input in the same cycle.
- R3: A path that is open at a rising clock edge loads the near-port input into its storage. After the hold strobe rises while the path enable is low, the output keeps the value loaded at the last open edge. Near-port input changes made in the same cycle as the strobe rise, or later, do not affect the output.
- R4: While a path enable is high, that path's storage does not load, whatever the level of the hold strobe and the input data. When the path enable is later lowered with the hold strobe high, the output shows the older stored value.
- R5: The far-port drive-enable bits of a path are all 1 only when both its path enable and its drive enable are low. Otherwise they are all 0, and the output data is 0.
- R6: The B-to-A path behaves exactly like the A-to-B path, using `ba_*` controls, B input and A outputs. It has storage separate from the A-to-B path.
- R7: Channel c occupies bus bits [8c+7:8c] and responds only to control bit c. Operating one channel leaves the outputs and the stored value of the other channel unchanged.
- R8: Both paths of a channel can hold different values at the same time and can both drive at the same time, each onto its own port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | A-bus value seen at the block |
| b_in | input | 16 | B-bus value seen at the block |
| ab_pen_n | input | 2 | A-to-B path enable per channel, active low |
| ab_hold_n | input | 2 | A-to-B hold strobe per channel, active low transparent |
| ab_oen_n | input | 2 | A-to-B drive enable per channel, active low |
| ba_pen_n | input | 2 | B-to-A path enable per channel, active low |
| ba_hold_n | input | 2 | B-to-A hold strobe per channel, active low transparent |
| ba_oen_n | input | 2 | B-to-A drive enable per channel, active low |
| b_out | output | 16 | Data offered to the B bus |
| b_drv | output | 16 | Per-bit B-bus drive enable |
| a_out | output | 16 | Data offered to the A bus |
| a_drv | output | 16 | Per-bit A-bus drive enable |

## Verification
Two things can happen in the same cycle: the hold strobe rises, and the near-port data changes. The bench makes both changes in one step. It expects the far port to keep showing the value loaded at the previous edge, not the new input. A second pairing is one channel loading while the other channel is already holding. The bench drives both channels in the same cycle and compares each byte of both ports against an independent reference storage element per path.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Active-low controls for one direction of one channel
  typedef struct packed {
    logic pen_n;   // path enable
    logic hold_n;  // low = transparent, rising = freeze
    logic oen_n;   // far-port drive enable
  } path_ctrl_t;

endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  path_ctrl_t   ctrl,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out,
  output logic [W-1:0] q_drv
);

  logic         open_w;
  logic         drive_w;
  logic [W-1:0] held;
  logic [W-1:0] view;

  assign open_w  = ~ctrl.pen_n & ~ctrl.hold_n;
  assign drive_w = ~ctrl.pen_n & ~ctrl.oen_n;

  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (open_w) held <= d_in;
  end

  assign view  = open_w ? d_in : held;
  assign q_out = (drive_w && !rst) ? view : '0;
  assign q_drv = {W{drive_w && !rst}};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> held == '0) else $error("reset"); // R1

  AST_OPEN_LOADS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.pen_n && !ctrl.hold_n) |=> held == $past(d_in)) else $error("load"); // R3

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.pen_n && ctrl.hold_n) |=> $stable(held)) else $error("freeze"); // R3

  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ctrl.pen_n |=> $stable(held)) else $error("disabled"); // R4

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.pen_n && !ctrl.hold_n && !ctrl.oen_n) |-> q_out == d_in) else $error("transp"); // R2

endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel
  import bus_xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  path_ctrl_t   ab_ctrl,
  input  path_ctrl_t   ba_ctrl,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_drv,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_drv
);

  xcvr_path #(.W(W)) u_ab (
    .clk(clk), .rst(rst), .ctrl(ab_ctrl), .d_in(a_in),
    .q_out(b_out), .q_drv(b_drv)
  );

  xcvr_path #(.W(W)) u_ba (
    .clk(clk), .rst(rst), .ctrl(ba_ctrl), .d_in(b_in),
    .q_out(a_out), .q_drv(a_drv)
  );

  AST_DRV_UNIFORM: assert property (@(posedge clk) disable iff (rst)
    (b_drv == '0 || b_drv == '1) && (a_drv == '0 || a_drv == '1)) else $error("drv"); // R5

endmodule

// File: rtl/bus_xcvr_latched.sv
module bus_xcvr_latched
  import bus_xcvr_pkg::*;
#(
  parameter int CH_W   = 8,
  parameter int NUM_CH = 2,
  localparam int BUS_W = CH_W * NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_W-1:0]  a_in,
  input  logic [BUS_W-1:0]  b_in,
  input  logic [NUM_CH-1:0] ab_pen_n,
  input  logic [NUM_CH-1:0] ab_hold_n,
  input  logic [NUM_CH-1:0] ab_oen_n,
  input  logic [NUM_CH-1:0] ba_pen_n,
  input  logic [NUM_CH-1:0] ba_hold_n,
  input  logic [NUM_CH-1:0] ba_oen_n,
  output logic [BUS_W-1:0]  b_out,
  output logic [BUS_W-1:0]  b_drv,
  output logic [BUS_W-1:0]  a_out,
  output logic [BUS_W-1:0]  a_drv
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    path_ctrl_t ab_c;
    path_ctrl_t ba_c;
    assign ab_c = '{pen_n: ab_pen_n[c], hold_n: ab_hold_n[c], oen_n: ab_oen_n[c]};
    assign ba_c = '{pen_n: ba_pen_n[c], hold_n: ba_hold_n[c], oen_n: ba_oen_n[c]};

    xcvr_channel #(.W(CH_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .ab_ctrl(ab_c),
      .ba_ctrl(ba_c),
      .a_in   (a_in[c*CH_W +: CH_W]),
      .b_in   (b_in[c*CH_W +: CH_W]),
      .b_out  (b_out[c*CH_W +: CH_W]),
      .b_drv  (b_drv[c*CH_W +: CH_W]),
      .a_out  (a_out[c*CH_W +: CH_W]),
      .a_drv  (a_drv[c*CH_W +: CH_W])
    );
  end

endmodule

// File: tb/test_bus_xcvr_latched.sv
module test_bus_xcvr_latched;
  localparam int CH_W = 8;
  localparam int NUM_CH = 2;
  localparam int BW = CH_W * NUM_CH;

  logic clk = 1'b0;
  logic rst;
  logic [BW-1:0] a_in, b_in;
  logic [NUM_CH-1:0] ab_pen_n, ab_hold_n, ab_oen_n, ba_pen_n, ba_hold_n, ba_oen_n;
  logic [BW-1:0] b_out, b_drv, a_out, a_drv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [CH_W-1:0] ref_ab [NUM_CH];
  logic [CH_W-1:0] ref_ba [NUM_CH];

  always #2.5 clk = ~clk;

  bus_xcvr_latched #(.CH_W(CH_W), .NUM_CH(NUM_CH)) i_bus_xcvr_latched (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_pen_n(ab_pen_n), .ab_hold_n(ab_hold_n), .ab_oen_n(ab_oen_n),
    .ba_pen_n(ba_pen_n), .ba_hold_n(ba_hold_n), .ba_oen_n(ba_oen_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  // Reference storage per path and channel, built from R1..R4
  always @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (rst) begin
        ref_ab[c] <= '0;
        ref_ba[c] <= '0;
      end else begin
        if (!ab_pen_n[c] && !ab_hold_n[c]) ref_ab[c] <= a_in[c*CH_W +: CH_W];
        if (!ba_pen_n[c] && !ba_hold_n[c]) ref_ba[c] <= b_in[c*CH_W +: CH_W];
      end
    end
  end

  task automatic cmp(input string tag, input string what, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Compare all four output vectors against the reference
  task automatic check_all(input string tag);
    logic [BW-1:0] eb, ebd, ea, ead;
    for (int c = 0; c < NUM_CH; c++) begin
      logic go_ab, go_ba, dr_ab, dr_ba;
      logic [CH_W-1:0] v_ab, v_ba;
      go_ab = !ab_pen_n[c] && !ab_hold_n[c];
      go_ba = !ba_pen_n[c] && !ba_hold_n[c];
      dr_ab = !ab_pen_n[c] && !ab_oen_n[c] && !rst;
      dr_ba = !ba_pen_n[c] && !ba_oen_n[c] && !rst;
      v_ab = go_ab ? a_in[c*CH_W +: CH_W] : ref_ab[c];
      v_ba = go_ba ? b_in[c*CH_W +: CH_W] : ref_ba[c];
      eb[c*CH_W +: CH_W]  = dr_ab ? v_ab : '0;
      ebd[c*CH_W +: CH_W] = {CH_W{dr_ab}};
      ea[c*CH_W +: CH_W]  = dr_ba ? v_ba : '0;
      ead[c*CH_W +: CH_W] = {CH_W{dr_ba}};
    end
    cmp(tag, "b_out", b_out, eb);
    cmp(tag, "b_drv", b_drv, ebd);
    cmp(tag, "a_out", a_out, ea);
    cmp(tag, "a_drv", a_drv, ead);
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic settle;
    #1;
  endtask

  task automatic all_idle;
    ab_pen_n = '1; ab_hold_n = '1; ab_oen_n = '1;
    ba_pen_n = '1; ba_hold_n = '1; ba_oen_n = '1;
  endtask

  task automatic t_reset; // R1
    step(); rst = 1; ab_pen_n = '0; ab_oen_n = '0; ab_hold_n = '1; a_in = 16'hFFFF;
    settle(); check_all("R1");
    cmp("R1", "b_drv in reset", b_drv, '0);
    step(); rst = 0; settle();
    cmp("R1", "b_out after reset", b_out, '0);
    check_all("R1");
    step(); all_idle();
  endtask

  task automatic t_transparent; // R2
    step(); ab_pen_n = '0; ab_hold_n = '0; ab_oen_n = '0; a_in = 16'h1234;
    settle(); cmp("R2", "b_out transp", b_out, 16'h1234); check_all("R2");
    step(); a_in = 16'hA5C3; settle(); cmp("R2", "b_out transp2", b_out, 16'hA5C3);
    step(); a_in = 16'h0F0F; settle(); check_all("R2");
  endtask

  task automatic t_capture; // R3, strobe rise and data change in the same step
    step(); ab_pen_n = '0; ab_hold_n = '0; ab_oen_n = '0; a_in = 16'h5566;
    settle(); check_all("R3");
    step(); ab_hold_n = '1; a_in = 16'h99AA;
    settle(); cmp("R3", "b_out held", b_out, 16'h5566); check_all("R3");
    step(); a_in = 16'h0000; settle(); cmp("R3", "b_out still held", b_out, 16'h5566);
  endtask

  task automatic t_disabled; // R4
    step(); ab_pen_n = '1; ab_hold_n = '0; a_in = 16'hDEAD;
    settle(); cmp("R4", "b_drv off", b_drv, '0);
    step(); a_in = 16'hBEEF; step();
    ab_hold_n = '1; ab_pen_n = '0; ab_oen_n = '0;
    settle(); cmp("R4", "b_out old", b_out, 16'h5566); check_all("R4");
  endtask

  task automatic t_drive; // R5
    step(); ab_pen_n = '0; ab_hold_n = '1; ab_oen_n = '1;
    settle(); cmp("R5", "oen high drv", b_drv, '0); cmp("R5", "oen high data", b_out, '0);
    step(); ab_pen_n = '1; ab_oen_n = '0;
    settle(); cmp("R5", "pen high drv", b_drv, '0); check_all("R5");
    step(); ab_pen_n = '0; settle(); cmp("R5", "both low drv", b_drv, '1);
    step(); all_idle();
  endtask

  task automatic t_reverse; // R6
    step(); ba_pen_n = '0; ba_hold_n = '0; ba_oen_n = '0; b_in = 16'h7E81;
    settle(); cmp("R6", "a_out transp", a_out, 16'h7E81); check_all("R6");
    step(); ba_hold_n = '1; b_in = 16'h1111;
    settle(); cmp("R6", "a_out held", a_out, 16'h7E81); check_all("R6");
    step(); all_idle();
  endtask

  task automatic t_channels; // R7
    step(); ab_pen_n = 2'b00; ab_oen_n = 2'b00; ab_hold_n = 2'b11; a_in = 16'h3344;
    settle(); check_all("R7");
    step(); ab_hold_n = 2'b10; a_in = 16'hC0DE;   // only channel 0 open
    settle(); check_all("R7");
    step(); ab_hold_n = 2'b11; a_in = 16'h0000;
    settle(); cmp("R7", "b_out split", b_out, {8'h55, 8'hDE}); check_all("R7");
    step(); ab_oen_n = 2'b01; settle(); cmp("R7", "b_drv ch1 only", b_drv, 16'hFF00);
    step(); all_idle();
  endtask

  task automatic t_both; // R8
    step(); ab_pen_n = '0; ab_hold_n = '0; ba_pen_n = '0; ba_hold_n = '0;
    a_in = 16'hAAAA; b_in = 16'h5555; settle(); check_all("R8");
    step(); ab_hold_n = '1; ba_hold_n = '1; ab_oen_n = '0; ba_oen_n = '0;
    a_in = 16'h0101; b_in = 16'h0202;
    settle(); cmp("R8", "b_out", b_out, 16'hAAAA); cmp("R8", "a_out", a_out, 16'h5555);
    check_all("R8");
    step(); all_idle();
  endtask

  initial begin
    rst = 1; a_in = '0; b_in = '0; all_idle();
    step(); step();
    t_reset();
    t_transparent();
    t_capture();
    t_disabled();
    t_drive();
    t_reverse();
    t_channels();
    t_both();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule